// File: doc/BRIEF.md
# Asynchronous DRAM Access Sequencer

This block sits between a simple single-word processor bus and an asynchronous DRAM array. It accepts one read or store request at a time and generates the active-low control sequence the memory needs. The address is placed on a shared multiplexed bus, first as the row and then as the column. A row strobe for the addressed bank falls, then column strobes fall on the enabled byte lanes, with a write enable held low for stores. When the access window closes, read data is latched and a single-cycle completion pulse is raised. All strobes then stay high for a precharge window, and the next request is taken only after that window ends.

The processor-to-memory address wiring is fixed. Byte address bits 10 to 20 form the row, with bit 10 landing on memory address line 0. Bit 21 selects one of two banks. Column bits are gathered from bits 9 and 22 to 27. Bits 0 to 8 are not used for memory addressing. Each timing window is a parameter counted in clock cycles.

Top module: `dram_strobe_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy` and `done` are 0, every row and column strobe is high (inactive) and the write enable is high.
- R2: During the row setup and row-to-column windows, `dram_addr[10:0]` equals `req_addr[20:10]` of the accepted request (memory line 0 carries byte address bit 10).
- R3: During the column setup cycle and the column access window, `dram_addr` equals the column word: bit 0 is `req_addr[9]`, bits 6:1 are `req_addr[27:22]`, and bits 10:7 are 0.
- R4: Strobe order: no column strobe is low unless a row strobe is low, and the row strobe falls one full cycle before the column address appears on the bus.
- R5: The windows last, in order, `T_ROW_SETUP` cycles (all strobes high, row address driven), `T_ROW_TO_COL` cycles (row strobe low), exactly one column setup cycle (row strobe low, column address driven, column strobes high), and `T_COL_ACCESS` cycles (column strobes low). Each parameter is at least 1.
- R6: For a store (`req_write`=1), `dram_we_n` is low and `dram_dq_oe` is high from the first row setup cycle through the last column access cycle, with `dram_dq_out` equal to the request data. For a read, `dram_we_n` stays high and `dram_dq_oe` stays low.
- R7: Only the row strobe `dram_ras_n[req_addr[21]]` goes low. Column strobe `dram_cas_n[i]` goes low exactly when `req_be[i]` is 1 (lane i is data bits 8i+7:8i).
- R8: For a read, `rdata` takes the value of `dram_dq_in` sampled at the clock edge that ends the last column access cycle. `done` is high for exactly the one following cycle.
- R9: `done` coincides with the first of `T_PRECHARGE` cycles in which all strobes are high and `busy` is still 1. `busy` falls in the cycle after the window ends.
- R10: A request presented while `busy` is 1 is ignored: it starts no access, neither then nor later.
- R11: Byte address bits 8:0 have no effect on the memory address bus, strobes or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present; taken when `busy` is 0 |
| req_write | input | 1 | 1 = store, 0 = read |
| req_addr | input | 28 | Processor byte address |
| req_be | input | 4 | Byte-lane enables |
| req_wdata | input | 32 | Store data |
| busy | output | 1 | Access or precharge in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Latched read data |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 2 | Row strobes, one per bank, active low |
| dram_cas_n | output | 4 | Column strobes, one per byte lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 32 | Store data toward the memory |
| dram_dq_oe | output | 1 | Data bus drive enable |
| dram_dq_in | input | 32 | Data returned by the memory |

## Verification
The embedded properties assume the requester watches `busy` and that `dram_dq_in` is stable at the edge that closes the column access window. They also assume each timing parameter is at least one cycle. The stimulus drives requests only on falling edges. It drops a request after its accepting edge, and it also presents a deliberate request while `busy` is high and withdraws it before the block goes idle. The memory model places read data on the bus at the column setup cycle and holds it through the access window. The stimulus also scrambles the request inputs once a request has been accepted, so that any use of live inputs instead of latched ones shows on the bus.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    // Widths of the processor side and the memory side
    localparam int CPU_AW   = 28;
    localparam int DRAM_AW  = 11;
    localparam int LANES    = 4;
    localparam int DQ_W     = 8 * LANES;
    localparam int BANKS    = 2;
    localparam int BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1;

    // Fixed address wiring
    localparam int ROW_LSB    = 10;
    localparam int BANK_BIT   = ROW_LSB + DRAM_AW;   // 21
    localparam int COL_LO_BIT = ROW_LSB - 1;         // 9
    localparam int COL_HI_LSB = BANK_BIT + 1;        // 22
    localparam int COL_HI_W   = CPU_AW - COL_HI_LSB; // 6

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RSU,   // row address set up, strobes high
        PH_RCD,   // row strobe low, row address held
        PH_CSU,   // column address set up, column strobes high
        PH_CAS,   // column strobes low
        PH_PRE    // all strobes high
    } phase_e;

    typedef struct packed {
        logic              write;
        logic [CPU_AW-1:0] addr;
        logic [LANES-1:0]  be;
        logic [DQ_W-1:0]   wdata;
    } dram_req_t;

    function automatic logic [DRAM_AW-1:0] row_of(input logic [CPU_AW-1:0] a);
        return a[ROW_LSB +: DRAM_AW];
    endfunction

    function automatic logic [DRAM_AW-1:0] col_of(input logic [CPU_AW-1:0] a);
        logic [DRAM_AW-1:0] c;
        c    = '0;
        c[0] = a[COL_LO_BIT];
        for (int i = 0; i < COL_HI_W; i++) begin
            c[i+1] = a[COL_HI_LSB + i];
        end
        return c;
    endfunction

    function automatic logic [BANK_W-1:0] bank_of(input logic [CPU_AW-1:0] a);
        return BANK_W'(a[BANK_BIT]);
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dram_phase_timer.sv
module dram_phase_timer
    import dram_seq_pkg::*;
#(
    parameter int T_ROW_SETUP  = 1,
    parameter int T_ROW_TO_COL = 2,
    parameter int T_COL_ACCESS = 2,
    parameter int T_PRECHARGE  = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_e phase,
    output logic   cas_end
);

    localparam int T_MAX = max4(T_ROW_SETUP, T_ROW_TO_COL, T_COL_ACCESS, T_PRECHARGE);
    localparam int CW    = (T_MAX > 1) ? $clog2(T_MAX) : 1;

    logic [CW-1:0] cnt;
    logic          at_zero;

    assign at_zero = (cnt == '0);
    assign cas_end = (phase == PH_CAS) && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_RSU;
                    cnt   <= CW'(T_ROW_SETUP - 1);
                end
                PH_RSU: if (at_zero) begin
                    phase <= PH_RCD;
                    cnt   <= CW'(T_ROW_TO_COL - 1);
                end else cnt <= cnt - 1'b1;
                PH_RCD: if (at_zero) begin
                    phase <= PH_CSU;
                    cnt   <= '0;
                end else cnt <= cnt - 1'b1;
                PH_CSU: begin
                    phase <= PH_CAS;
                    cnt   <= CW'(T_COL_ACCESS - 1);
                end
                PH_CAS: if (at_zero) begin
                    phase <= PH_PRE;
                    cnt   <= CW'(T_PRECHARGE - 1);
                end else cnt <= cnt - 1'b1;
                PH_PRE: if (at_zero) begin
                    phase <= PH_IDLE;
                end else cnt <= cnt - 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R5: the column setup window is a single cycle
    p_csu_single_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CSU) |=> (phase == PH_CAS));

    // R4: column access is entered only from column setup
    p_cas_entry_r4: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_CAS) && ($past(phase) != PH_CAS)) |-> ($past(phase) == PH_CSU));

    // R5: the access window counter never exceeds its length
    p_cas_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CAS) |-> (int'(cnt) < T_COL_ACCESS));

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_seq_pkg::*;
(
    input  logic [CPU_AW-1:0]  addr,
    input  phase_e             phase,
    output logic [DRAM_AW-1:0] dram_addr,
    output logic [BANK_W-1:0]  bank
);

    always_comb begin
        unique case (phase)
            PH_RSU, PH_RCD: dram_addr = row_of(addr);
            PH_CSU, PH_CAS: dram_addr = col_of(addr);
            default:        dram_addr = '0;
        endcase
    end

    assign bank = bank_of(addr);

endmodule

// File: rtl/dram_strobe_gen.sv
module dram_strobe_gen
    import dram_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic [BANK_W-1:0] bank,
    input  logic [LANES-1:0]  be,
    input  logic              write,
    output logic [BANKS-1:0]  ras_n,
    output logic [LANES-1:0]  cas_n,
    output logic              we_n,
    output logic              dq_oe
);

    logic ras_on;
    logic cas_on;
    logic acc_on;

    assign ras_on = (phase == PH_RCD) || (phase == PH_CSU) || (phase == PH_CAS);
    assign cas_on = (phase == PH_CAS);
    assign acc_on = (phase == PH_RSU) || ras_on;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign ras_n[b] = !(ras_on && (bank == BANK_W'(b)));
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign cas_n[l] = !(cas_on && be[l]);
    end

    assign we_n  = !(acc_on && write);
    assign dq_oe = acc_on && write;

    // R4: a column strobe is never low without a row strobe low
    p_cas_needs_ras_r4: assert property (@(posedge clk) disable iff (rst)
        (cas_n != '1) |-> (ras_n != '1));

    // R7: at most one bank strobed at a time
    p_one_bank_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(~ras_n) <= 1);

    // R6: the write enable is only low while the bus is driven
    p_we_with_oe_r6: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> dq_oe);

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
    import dram_seq_pkg::*;
#(
    parameter int T_ROW_SETUP  = 1,
    parameter int T_ROW_TO_COL = 2,
    parameter int T_COL_ACCESS = 2,
    parameter int T_PRECHARGE  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [CPU_AW-1:0]  req_addr,
    input  logic [LANES-1:0]   req_be,
    input  logic [DQ_W-1:0]    req_wdata,
    output logic               busy,
    output logic               done,
    output logic [DQ_W-1:0]    rdata,
    output logic [DRAM_AW-1:0] dram_addr,
    output logic [BANKS-1:0]   dram_ras_n,
    output logic [LANES-1:0]   dram_cas_n,
    output logic               dram_we_n,
    output logic [DQ_W-1:0]    dram_dq_out,
    output logic               dram_dq_oe,
    input  logic [DQ_W-1:0]    dram_dq_in
);

    phase_e            phase;
    logic              cas_end;
    logic              accept;
    dram_req_t         cur;
    logic [BANK_W-1:0] bank;
    logic              done_q;
    logic [DQ_W-1:0]   rdata_q;

    assign accept = (phase == PH_IDLE) && req_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (accept) begin
            cur.write <= req_write;
            cur.addr  <= req_addr;
            cur.be    <= req_be;
            cur.wdata <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= cas_end;
            if (cas_end && !cur.write) begin
                rdata_q <= dram_dq_in;
            end
        end
    end

    dram_phase_timer #(
        .T_ROW_SETUP  (T_ROW_SETUP),
        .T_ROW_TO_COL (T_ROW_TO_COL),
        .T_COL_ACCESS (T_COL_ACCESS),
        .T_PRECHARGE  (T_PRECHARGE)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .phase   (phase),
        .cas_end (cas_end)
    );

    dram_addr_mux u_amux (
        .addr      (cur.addr),
        .phase     (phase),
        .dram_addr (dram_addr),
        .bank      (bank)
    );

    dram_strobe_gen u_strb (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .bank  (bank),
        .be    (cur.be),
        .write (cur.write),
        .ras_n (dram_ras_n),
        .cas_n (dram_cas_n),
        .we_n  (dram_we_n),
        .dq_oe (dram_dq_oe)
    );

    assign busy        = (phase != PH_IDLE);
    assign done        = done_q;
    assign rdata       = rdata_q;
    assign dram_dq_out = cur.wdata;

    // R1: reset leaves the block idle and quiet
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!busy && !done && (dram_ras_n == '1) && (dram_cas_n == '1) && dram_we_n));

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: completion falls inside the precharge window
    p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy && (dram_ras_n == '1) && (dram_cas_n == '1) && dram_we_n));

    // R10: the latched request cannot change while busy
    p_hold_busy_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cur));

    // R6: reads never pull the write enable low
    p_read_we_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !cur.write) |-> (dram_we_n && !dram_dq_oe));

endmodule

// File: tb/dram_strobe_seq_tb.sv
module dram_strobe_seq_tb;

    localparam int RSU = 2;
    localparam int RCD = 3;
    localparam int CAC = 2;
    localparam int PRE = 3;
    localparam int K_RCD = RSU + 1;
    localparam int K_CSU = RSU + RCD + 1;
    localparam int K_CAS = K_CSU + 1;
    localparam int K_PRE = K_CAS + CAC;
    localparam int K_END = K_PRE + PRE - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [27:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, done, dram_we_n, dram_dq_oe;
    logic [31:0] rdata, dram_dq_out;
    logic [31:0] dram_dq_in = '0;
    logic [10:0] dram_addr;
    logic [1:0]  dram_ras_n;
    logic [3:0]  dram_cas_n;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    typedef struct { bit wr; logic [31:0] exp; } sb_item_t;
    sb_item_t sbq[$];
    logic [31:0] mem [int];

    always #2.5 clk = ~clk;

    dram_strobe_seq #(
        .T_ROW_SETUP (RSU), .T_ROW_TO_COL (RCD),
        .T_COL_ACCESS(CAC), .T_PRECHARGE  (PRE)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mem_rd(input int k);
        return mem.exists(k) ? mem[k] : (32'h5A3C_0000 ^ k);
    endfunction

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

    // Scoreboard monitor (R8): every done pops one expected item
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R8 unexpected done", 64'(done), 64'(0));
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                if (!it.wr) check(rdata == it.exp, "R8 read data", 64'(rdata), 64'(it.exp));
            end
        end
    end

    task automatic access(input logic [27:0] a, input bit wr, input logic [3:0] be,
                          input logic [31:0] wd, input bit poke);
        logic [10:0] row, col, eaddr;
        logic [1:0]  eras;
        logic [3:0]  ecas;
        logic        ewe, edone;
        int          key;
        logic [31:0] rdv;
        sb_item_t    it;
        row  = a[20:10];
        col  = {4'b0000, a[27:22], a[9]};
        eras = a[21] ? 2'b01 : 2'b10;
        key  = int'(a[27:9]);
        rdv  = mem_rd(key) & lane_mask(be);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        @(posedge clk);
        it.wr = wr; it.exp = rdv;
        sbq.push_back(it);
        for (int k = 1; k <= K_END; k++) begin
            @(negedge clk);
            if (k == 1) begin
                req_valid = 1'b0; req_addr = ~a; req_be = ~be; req_wdata = ~wd; req_write = ~wr;
            end
            if (poke && k == 4) begin
                req_valid = 1'b1; req_addr = a ^ 28'h0200400;
            end
            if (poke && k == 5) req_valid = 1'b0;
            if (k == K_CSU) dram_dq_in = wr ? 32'hDEAD_BEEF : rdv;
            ewe = !(wr && k < K_PRE);
            edone = (k == K_PRE);
            if (k < K_RCD) begin
                eaddr = row; ecas = 4'hF;
                check({dram_addr, dram_ras_n, dram_cas_n} == {eaddr, 2'b11, ecas},
                      "R2/R5 row setup", 64'({dram_addr, dram_ras_n, dram_cas_n}), 64'({eaddr, 2'b11, ecas}));
            end else if (k < K_CSU) begin
                check({dram_addr, dram_ras_n, dram_cas_n} == {row, eras, 4'hF},
                      "R2/R7 row strobe", 64'({dram_addr, dram_ras_n, dram_cas_n}), 64'({row, eras, 4'hF}));
            end else if (k == K_CSU) begin
                check({dram_addr, dram_ras_n, dram_cas_n} == {col, eras, 4'hF},
                      "R3/R4 column setup", 64'({dram_addr, dram_ras_n, dram_cas_n}), 64'({col, eras, 4'hF}));
            end else if (k < K_PRE) begin
                ecas = ~be;
                check({dram_addr, dram_ras_n, dram_cas_n} == {col, eras, ecas},
                      "R3/R7/R11 column access", 64'({dram_addr, dram_ras_n, dram_cas_n}), 64'({col, eras, ecas}));
                if (wr) check(dram_dq_oe && dram_dq_out == wd, "R6 store data",
                              64'({dram_dq_oe, dram_dq_out}), 64'({1'b1, wd}));
            end else begin
                check({dram_ras_n, dram_cas_n} == 6'h3F, "R9 precharge quiet",
                      64'({dram_ras_n, dram_cas_n}), 64'h3F);
            end
            check(dram_we_n == ewe && dram_dq_oe == !ewe, "R6 write enable",
                  64'({dram_we_n, dram_dq_oe}), 64'({ewe, !ewe}));
            check(busy && done == edone, "R5/R8/R9 busy and done", 64'({busy, done}), 64'({1'b1, edone}));
        end
        if (wr) mem[key] = (mem_rd(key) & ~lane_mask(be)) | (wd & lane_mask(be));
        @(negedge clk);
        check(!busy && !done, "R9 idle after precharge", 64'({busy, done}), 64'(0));
        if (poke) begin
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                check(!busy && dram_ras_n == 2'b11 && dram_cas_n == 4'hF,
                      "R10 request during busy ignored", 64'({busy, dram_ras_n, dram_cas_n}), 64'h3F);
            end
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            if (sbq.size() != 0) check(1'b0, "R8 missing done", 64'(sbq.size()), 64'(0));
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'(0), 64'(1));
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && dram_ras_n == 2'b11 && dram_cas_n == 4'hF && dram_we_n,
              "R1 reset state", 64'({busy, done, dram_ras_n, dram_cas_n, dram_we_n}), 64'h7F);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && dram_ras_n == 2'b11 && dram_cas_n == 4'hF && dram_we_n,
              "R1 after reset", 64'({busy, done, dram_ras_n, dram_cas_n, dram_we_n}), 64'h7F);
        // plain read, bank 0, then bank 1
        access(28'h0012_3400, 1'b0, 4'hF, 32'h0, 1'b0);
        access(28'h0A2A_A600, 1'b0, 4'hF, 32'h0, 1'b0);
        // full and partial stores with read-back
        access(28'h0055_5200, 1'b1, 4'hF, 32'h1122_3344, 1'b0);
        access(28'h0055_5200, 1'b0, 4'hF, 32'h0, 1'b0);
        access(28'h0F35_5A00, 1'b1, 4'b0101, 32'hAABB_CCDD, 1'b0);
        access(28'h0F35_5A00, 1'b0, 4'hF, 32'h0, 1'b0);
        access(28'h0F35_5A00, 1'b0, 4'b1000, 32'h0, 1'b0);
        // R11: low bits vary, same word
        access(28'h0055_53FF, 1'b0, 4'hF, 32'h0, 1'b0);
        access(28'h0055_5317, 1'b0, 4'b0010, 32'h0, 1'b0);
        // R10: request presented while busy
        access(28'h0300_0600, 1'b1, 4'b0011, 32'h0BAD_F00D, 1'b1);
        access(28'h0300_0600, 1'b0, 4'hF, 32'h0, 1'b1);
        // walking one across every address bit that reaches the memory
        for (int b = 9; b < 28; b++) begin
            access(28'(1) << b, 1'b0, 4'hF, 32'h0, 1'b0);
        end
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule